// File: doc/BRIEF.md
# Dual-Mode Colour Matrix and 3x3 Convolution Engine

This block is a pipelined arithmetic engine with two run-time modes that share one bank of nine multipliers. In matrix mode every accepted input carries the three colour components of a single pixel. The block returns three weighted sums per pixel, one for each row of a 3x3 coefficient matrix. In convolution mode every accepted input carries one column of three vertically adjacent pixels. The block keeps the three most recent columns as a 3x3 window, multiplies the window by the nine coefficients and returns the total.

The nine coefficients are signed and are loaded through a small indexed write port, normally before a stream starts. A write is allowed during a stream. It affects only pixels captured at or after the clock edge that performs it. Pixels are unsigned. Results are signed and 24 bits wide, so they cannot overflow. Line buffering, edge padding and self-test are done outside the block.

Top module: `mcv_engine`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and every res_o lane is 0.
- R2: A write with coef_we_i high and coef_idx_i in 0..8 stores coef_val_i as coefficient C[coef_idx_i] at that clock edge. Index 3k+j is row k, column j. A pixel captured at the same edge already uses the new value.
- R3: A write with coef_idx_i in 9..15 has no effect on any result.
- R4: Matrix mode (mode_i=0): for input x_j = pix_i[j], the output is res_o[k] = C[3k]*x_0 + C[3k+1]*x_1 + C[3k+2]*x_2, for k = 0, 1, 2.
- R5: Matrix mode: every cycle with in_valid_i high produces one valid result. Back-to-back inputs give back-to-back outputs.
- R6: Convolution mode (mode_i=1): res_o[0] = sum over r,t of C[3r+t]*W[r][t], where W[r][0] is pix_i[r] of the current column and W[r][1] and W[r][2] are lane r of the previous two accepted columns. res_o[1] and res_o[2] are 0.
- R7: In convolution mode, the first two accepted columns after reset, or after mode_i differs from its value in the previous cycle, give no valid output. The third and later columns do.
- R8: An input captured at clock edge n has its result on the outputs after edge n+3. out_valid_o is high only for such results.
- R9: A coefficient write at edge n+1 or later does not change the result of a pixel captured at edge n.
- R10: Pixels are unsigned 10-bit and coefficients are two's-complement 10-bit. Extreme operands (pixel 1023, coefficient -512 or 511) give the exact, sign-extended 24-bit result.
- R11: Cycles with in_valid_i low leave the convolution window untouched, so the window always holds the last three accepted columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = colour matrix, 1 = 3x3 convolution |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_idx_i | input | 4 | Coefficient index (0..8 used) |
| coef_val_i | input | 10 | Signed coefficient value |
| in_valid_i | input | 1 | Input pixel/column valid |
| pix_i | input | 3 x 10 | Lane j: colour component j, or row j of a column |
| out_valid_o | output | 1 | Result valid |
| res_o | output | 3 x 24 | Signed results; lanes 1 and 2 are zero in convolution mode |

## Verification
Every input captured at a rising edge must show its result after the third edge that follows, in both modes. This holds even when coefficients change on the edges around it. The bench runs a behavioural model at each input edge and queues the expected valid flag and the three lanes. The queue is primed with three empty entries, and one entry is popped and compared at every falling edge. So each comparison lands exactly where the four register stages place the result. A wrong latency, a wrong window fill rule or a coefficient read in the wrong stage all show up as mismatches in that same cycle.

// File: rtl/mcv_pkg.sv
package mcv_pkg;
  localparam int MCV_DIM    = 3;
  localparam int MCV_PIX_W  = 10;
  localparam int MCV_COEF_W = 10;
  localparam int MCV_SUM_W  = 24;
  localparam int MCV_IDX_W  = 4;

  typedef enum logic {
    MODE_MATRIX = 1'b0,
    MODE_CONV   = 1'b1
  } mcv_mode_e;
endpackage

// File: rtl/mcv_coef_bank.sv
module mcv_coef_bank #(
  parameter int DIM    = 3,
  parameter int COEF_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [COEF_W-1:0]               val_i,
  output logic [DIM*DIM-1:0][COEF_W-1:0]  coef_o
);
  localparam int NTAP = DIM * DIM;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              coef_o[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i))      coef_o[i] <= val_i;
    end

    AST_COEF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && idx_i == IDX_W'(i)) |=> coef_o[i] == $past(val_i)); // R2
  end

  AST_COEF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(coef_o)); // R2
  AST_COEF_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i >= IDX_W'(NTAP)) |=> $stable(coef_o)); // R3
endmodule

// File: rtl/mcv_window.sv
module mcv_window
  import mcv_pkg::*;
#(
  parameter int DIM   = 3,
  parameter int PIX_W = 10
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  valid_i,
  input  logic                                  mode_i,
  input  logic [DIM-1:0][PIX_W-1:0]             pix_i,
  output logic [DIM-1:0][DIM-1:0][PIX_W-1:0]    win_o,   // [row][age]
  output logic                                  vld_o,
  output logic                                  mode_o
);
  localparam int FILL_W   = $clog2(DIM);
  localparam int FILL_MAX = DIM - 1;

  logic              mode_q;
  logic [FILL_W-1:0] fill_q, fill_base;
  logic              restart;

  assign restart   = (mode_i != mode_q);
  assign fill_base = restart ? '0 : fill_q;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_MATRIX;
      fill_q <= '0;
      vld_o  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      vld_o  <= valid_i && (mode_i == MODE_MATRIX || fill_base == FILL_W'(FILL_MAX));
      if (mode_i == MODE_MATRIX)
        fill_q <= '0;
      else if (valid_i && fill_base != FILL_W'(FILL_MAX))
        fill_q <= fill_base + 1'b1;
      else
        fill_q <= fill_base;
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_o[r] <= '0;
      end else if (valid_i) begin
        win_o[r][0] <= pix_i[r];
        for (int t = 1; t < DIM; t++) win_o[r][t] <= win_o[r][t-1];
      end
    end
  end

  AST_WIN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> win_o[0][1] == $past(win_o[0][0])); // R11
  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(win_o)); // R11
  AST_FILL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_CONV && mode_q == MODE_MATRIX) |=> !vld_o); // R7
  AST_MATRIX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_MATRIX) |=> vld_o); // R5
endmodule

// File: rtl/mcv_mac.sv
module mcv_mac
  import mcv_pkg::*;
#(
  parameter int DIM    = 3,
  parameter int PIX_W  = 10,
  parameter int COEF_W = 10,
  parameter int SUM_W  = 24
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                vld_i,
  input  logic                                mode_i,
  input  logic [DIM-1:0][DIM-1:0][PIX_W-1:0]  win_i,
  input  logic [DIM*DIM-1:0][COEF_W-1:0]      coef_i,
  output logic                                vld_o,
  output logic                                mode_o,
  output logic [DIM-1:0][SUM_W-1:0]           row_o
);
  localparam int NTAP   = DIM * DIM;
  localparam int PROD_W = PIX_W + COEF_W;

  logic                          vld_p, mode_p;
  logic signed [PROD_W-1:0]      prod_q [NTAP];

  // stage 2: operand steering and products
  for (genvar i = 0; i < NTAP; i++) begin : g_mul
    localparam int R = i / DIM;
    localparam int T = i % DIM;
    logic        [PIX_W-1:0]  op;
    logic signed [PROD_W-1:0] op_ext, cf_ext;

    assign op     = (mode_i == MODE_CONV) ? win_i[R][T] : win_i[T][0];
    assign op_ext = PROD_W'(signed'({1'b0, op}));
    assign cf_ext = PROD_W'(signed'(coef_i[i]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[i] <= '0;
      else         prod_q[i] <= op_ext * cf_ext;
    end
  end

  // stage 3: per-row sums
  logic signed [SUM_W-1:0] row_d [DIM];
  always_comb begin
    for (int k = 0; k < DIM; k++) begin
      row_d[k] = '0;
      for (int j = 0; j < DIM; j++) row_d[k] = row_d[k] + SUM_W'(prod_q[k*DIM+j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_p  <= 1'b0;
      mode_p <= MODE_MATRIX;
      vld_o  <= 1'b0;
      mode_o <= MODE_MATRIX;
      row_o  <= '0;
    end else begin
      vld_p  <= vld_i;
      mode_p <= mode_i;
      vld_o  <= vld_p;
      mode_o <= mode_p;
      for (int k = 0; k < DIM; k++) row_o[k] <= row_d[k];
    end
  end

  AST_MAC_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ##1 vld_o); // R8
  AST_MAC_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ##1 (mode_o == $past(mode_i, 2))); // R8
endmodule

// File: rtl/mcv_engine.sv
module mcv_engine
  import mcv_pkg::*;
#(
  parameter int DIM    = MCV_DIM,
  parameter int PIX_W  = MCV_PIX_W,
  parameter int COEF_W = MCV_COEF_W,
  parameter int SUM_W  = MCV_SUM_W,
  parameter int IDX_W  = MCV_IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mode_i,
  input  logic                      coef_we_i,
  input  logic [IDX_W-1:0]          coef_idx_i,
  input  logic [COEF_W-1:0]         coef_val_i,
  input  logic                      in_valid_i,
  input  logic [DIM-1:0][PIX_W-1:0] pix_i,
  output logic                      out_valid_o,
  output logic [DIM-1:0][SUM_W-1:0] res_o
);
  localparam int NTAP = DIM * DIM;

  logic [NTAP-1:0][COEF_W-1:0]         coef;
  logic [DIM-1:0][DIM-1:0][PIX_W-1:0]  win;
  logic                                win_vld, win_mode;
  logic                                mac_vld, mac_mode;
  logic [DIM-1:0][SUM_W-1:0]           row;
  logic                                out_mode;

  mcv_coef_bank #(.DIM(DIM), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_coef (
    .clk_i, .rst_ni,
    .we_i  (coef_we_i),
    .idx_i (coef_idx_i),
    .val_i (coef_val_i),
    .coef_o(coef)
  );

  mcv_window #(.DIM(DIM), .PIX_W(PIX_W)) u_win (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i),
    .mode_i (mode_i),
    .pix_i  (pix_i),
    .win_o  (win),
    .vld_o  (win_vld),
    .mode_o (win_mode)
  );

  mcv_mac #(.DIM(DIM), .PIX_W(PIX_W), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_mac (
    .clk_i, .rst_ni,
    .vld_i (win_vld),
    .mode_i(win_mode),
    .win_i (win),
    .coef_i(coef),
    .vld_o (mac_vld),
    .mode_o(mac_mode),
    .row_o (row)
  );

  // stage 4: per-row results or total
  logic [SUM_W-1:0] total;
  always_comb begin
    total = '0;
    for (int k = 0; k < DIM; k++) total = total + row[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_mode    <= MODE_MATRIX;
      res_o       <= '0;
    end else begin
      out_valid_o <= mac_vld;
      out_mode    <= mac_mode;
      for (int k = 0; k < DIM; k++) begin
        if (mac_mode == MODE_CONV) res_o[k] <= (k == 0) ? total : '0;
        else                       res_o[k] <= row[k];
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |-> ##3 out_valid_o); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_vld |-> ##3 !out_valid_o); // R8
  AST_CONV_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_vld && mac_mode == MODE_CONV) |=> (res_o[1] == '0 && res_o[2] == '0)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && res_o == '0)); // R1
endmodule

// File: tb/mcv_engine_test.sv
module mcv_engine_test;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode = 1'b0;
  logic             we = 1'b0;
  logic [3:0]       idx = '0;
  logic [9:0]       val = '0;
  logic             vin = 1'b0;
  logic [2:0][9:0]  pix = '0;
  logic             vout;
  logic [2:0][23:0] res;

  int n_cmp = 0;
  int n_bad = 0;

  int coef [9];
  int hist [3][3];       // [row][age]
  int fill = 0;
  int prev_mode = 0;
  string cur_tag = "R4";

  bit    ev_q [$];
  int    e0_q [$], e1_q [$], e2_q [$];
  string tg_q [$];

  always #5 clk = ~clk;

  mcv_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .coef_we_i(we), .coef_idx_i(idx), .coef_val_i(val),
    .in_valid_i(vin), .pix_i(pix),
    .out_valid_o(vout), .res_o(res)
  );

  function automatic int sx10(int v);
    return (v >= 512) ? v - 1024 : v;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive at a falling edge, model the capturing edge, then compare after it
  task automatic cycle(int m, bit v, int a, int b, int c, bit w, int wi, int wv);
    bit ev;
    int e0, e1, e2;
    mode = m[0]; vin = v; we = w; idx = 4'(wi); val = 10'(wv);
    pix[0] = 10'(a); pix[1] = 10'(b); pix[2] = 10'(c);
    if (w && wi < 9) coef[wi] = sx10(wv);            // R2: same-edge write visible
    if (m != prev_mode) fill = 0;                     // R7: restart on mode change
    prev_mode = m;
    ev = 0; e0 = 0; e1 = 0; e2 = 0;
    if (v) begin
      for (int r = 0; r < 3; r++) begin
        hist[r][2] = hist[r][1]; hist[r][1] = hist[r][0];
      end
      hist[0][0] = a; hist[1][0] = b; hist[2][0] = c;
      if (m == 0) begin
        ev = 1;
        e0 = coef[0]*a + coef[1]*b + coef[2]*c;
        e1 = coef[3]*a + coef[4]*b + coef[5]*c;
        e2 = coef[6]*a + coef[7]*b + coef[8]*c;
      end else begin
        ev = (fill >= 2);
        for (int r = 0; r < 3; r++)
          for (int t = 0; t < 3; t++) e0 += coef[3*r+t] * hist[r][t];
        if (fill < 2) fill++;
      end
    end
    ev_q.push_back(ev); e0_q.push_back(e0); e1_q.push_back(e1); e2_q.push_back(e2);
    tg_q.push_back(cur_tag);
    @(negedge clk);
    begin
      bit    xv = ev_q.pop_front();
      int    x0 = e0_q.pop_front();
      int    x1 = e1_q.pop_front();
      int    x2 = e2_q.pop_front();
      string xt = tg_q.pop_front();
      check({"R8 valid ", xt}, int'(vout), int'(xv));
      if (xv && vout) begin
        check({xt, " lane0"}, int'($signed(res[0])), x0);
        check({xt, " lane1"}, int'($signed(res[1])), x1);
        check({xt, " lane2"}, int'($signed(res[2])), x2);
      end
    end
  endtask

  function automatic int rpix();
    return int'($urandom_range(0, 1023));
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) coef[i] = 0;
    for (int r = 0; r < 3; r++) for (int t = 0; t < 3; t++) hist[r][t] = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", int'(vout), 0);
    for (int k = 0; k < 3; k++) check("R1 data", int'(res[k]), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ev_q.push_back(0); e0_q.push_back(0); e1_q.push_back(0); e2_q.push_back(0);
      tg_q.push_back("R1");
    end

    // R2: load all nine coefficients
    cur_tag = "R2";
    for (int i = 0; i < 9; i++) cycle(0, 0, 0, 0, 0, 1, i, int'($urandom_range(0, 1023)));

    // R5: back-to-back matrix inputs
    cur_tag = "R5";
    for (int i = 0; i < 30; i++) cycle(0, 1, rpix(), rpix(), rpix(), 0, 0, 0);

    // R4: matrix with gaps
    cur_tag = "R4";
    for (int i = 0; i < 80; i++) cycle(0, $urandom_range(0, 3) != 0, rpix(), rpix(), rpix(), 0, 0, 0);

    // R9: writes during a stream affect only later captures
    cur_tag = "R9";
    for (int i = 0; i < 60; i++)
      cycle(0, 1, rpix(), rpix(), rpix(), $urandom_range(0, 2) == 0,
            int'($urandom_range(0, 8)), int'($urandom_range(0, 1023)));

    // R3: out-of-range indices are ignored
    cur_tag = "R3";
    for (int i = 0; i < 40; i++)
      cycle(0, 1, rpix(), rpix(), rpix(), 1, int'($urandom_range(9, 15)), int'($urandom_range(0, 1023)));

    // R10: extreme operands in both modes
    cur_tag = "R10";
    for (int i = 0; i < 9; i++) cycle(0, 0, 0, 0, 0, 1, i, 512);   // -512
    for (int i = 0; i < 4; i++) cycle(0, 1, 1023, 1023, 1023, 0, 0, 0);
    for (int i = 0; i < 5; i++) cycle(1, 1, 1023, 1023, 1023, 0, 0, 0);
    for (int i = 0; i < 9; i++) cycle(1, 1, 1023, 1023, 1023, 1, i, 511);
    for (int i = 0; i < 4; i++) cycle(1, 1, 1023, 1023, 1023, 0, 0, 0);
    for (int i = 0; i < 9; i++) cycle(1, 0, 0, 0, 0, 1, i, int'($urandom_range(0, 1023)));

    // R6 / R11: convolution with gaps
    cur_tag = "R6";
    for (int i = 0; i < 40; i++) cycle(1, 1, rpix(), rpix(), rpix(), 0, 0, 0);
    cur_tag = "R11";
    for (int i = 0; i < 100; i++) cycle(1, $urandom_range(0, 2) != 0, rpix(), rpix(), rpix(), 0, 0, 0);

    // R7: repeated mode changes restart the window fill
    cur_tag = "R7";
    for (int s = 0; s < 12; s++) begin
      int m = s % 2;
      int len = int'($urandom_range(1, 6));
      for (int i = 0; i < len; i++) cycle(m, $urandom_range(0, 3) != 0, rpix(), rpix(), rpix(), 0, 0, 0);
    end

    cur_tag = "R8";
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule